// File: doc/BRIEF.md
# Group Ownership Write Filter

This block decides, one 8-pin group at a time, which bus master may change a 32-bit register of a GPIO set. Two small ownership registers hold a 2-bit owner code for each group. The low bit of group g sits at bit 8g of the first register, and the high bit sits at bit 8g of the second. When a master writes a protected register of the set, the block builds the value to store. Each byte the master owns comes from the new value. Each byte it does not own keeps the old value.

Protected registers are the pin data, direction, interrupt enable, the three sensitivity selects, reset tolerance and debounce. Interrupt status and input mask writes are not filtered. The caller marks these writes as unprotected, and the new value then passes through whole. The merge is combinational, so the register that owns the storage latches the merged word on its own next clock edge. A write to an ownership register takes effect on the first cycle after its clock edge.

Top module: `gsf_cmd_src_filter`

## Requirements
- R1: After reset, both ownership registers read 0, so every group is owned by master code 0 (main CPU).
- R2: A write to an ownership register stores the write data ANDed with a mask that has only bit 0 of each group set (0x01010101 for four groups). Each register has its own strobe, and a register whose strobe is low holds its value.
- R3: The owner of group g is the 2-bit code {hi[8g], lo[8g]}, where lo and hi are the two ownership registers. The codes are 0 = main CPU, 1 = LPC host, 2 = coprocessor and 3 = reserved.
- R4: On a protected write, byte g of `merged_word` equals byte g of `new_word` when `wr_master` equals the owner of group g. Otherwise it equals byte g of `old_word`.
- R5: On an unprotected write (`wr_protected` = 0), `merged_word` equals `new_word`, whatever the owners are.
- R6: A master code of 3 changes no byte of a protected write, except a byte whose group owner is also 3.
- R7: Either ownership register can be written whatever value `wr_master` has.
- R8: `merged_word` follows its inputs in the same cycle. A change of ownership applies from the cycle after the clock edge that stores it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_wr_lo | input | 1 | Write strobe for the ownership register that holds the low bit of each owner code |
| own_wr_hi | input | 1 | Write strobe for the ownership register that holds the high bit of each owner code |
| own_wdata | input | 32 | Write data for the ownership registers |
| wr_master | input | 2 | Code of the master that makes the current write |
| wr_protected | input | 1 | 1 = the target register is filtered by ownership, 0 = bypass |
| old_word | input | 32 | Current content of the target register |
| new_word | input | 32 | Value the master is writing |
| merged_word | output | 32 | Value the target register must store |
| own_lo_q | output | 32 | Read back of the low-bit ownership register |
| own_hi_q | output | 32 | Read back of the high-bit ownership register |

## Verification
The assertions assume that reset is held low through the first clock edge. They also assume that the write data and strobes are driven to known values in every cycle after reset. They place no constraint on how master codes and protection flags combine, because every such combination is legal. The stimulus changes inputs only at falling edges and keeps the strobes low except in the single cycle of a deliberate ownership write. This keeps every check to one rising edge and rules out overlapping updates.

// File: rtl/gsf_pkg.sv
package gsf_pkg;
  localparam int unsigned OWNER_W = 2;

  typedef enum logic [OWNER_W-1:0] {
    MST_MAIN   = 2'd0,
    MST_HOST   = 2'd1,
    MST_COPROC = 2'd2,
    MST_RSVD   = 2'd3
  } master_e;
endpackage

// File: rtl/gsf_owner_regs.sv
module gsf_owner_regs
  import gsf_pkg::*;
#(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned DW     = GROUPS * GROUP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_lo,
  input  logic                      wr_hi,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             lo_q,
  output logic [DW-1:0]             hi_q,
  output logic [GROUPS*OWNER_W-1:0] owners
);
  // only the lowest bit of every group is storable
  logic [DW-1:0] keep_mask;

  always_comb begin
    keep_mask = '0;
    for (int g = 0; g < int'(GROUPS); g++) keep_mask[g*GROUP_W] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata & keep_mask;
      if (wr_hi) hi_q <= wdata & keep_mask;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_owner
    assign owners[g*OWNER_W +: OWNER_W] = {hi_q[g*GROUP_W], lo_q[g*GROUP_W]};
  end

  // R1: registers stay cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (lo_q == '0 && hi_q == '0));

  // R2: a strobed write lands masked, an idle register holds
  a_r2_lo_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == ($past(wdata) & keep_mask));
  a_r2_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> hi_q == ($past(wdata) & keep_mask));
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(lo_q));
  a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(hi_q));
endmodule

// File: rtl/gsf_group_merge.sv
module gsf_group_merge
  import gsf_pkg::*;
#(
  parameter int unsigned GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OWNER_W-1:0] owner,
  input  logic [OWNER_W-1:0] master,
  input  logic               protect,
  input  logic [GROUP_W-1:0] old_byte,
  input  logic [GROUP_W-1:0] new_byte,
  output logic [GROUP_W-1:0] out_byte
);
  logic take_new;

  always_comb begin
    take_new = !protect || (master == owner);
    out_byte = take_new ? new_byte : old_byte;
  end

  // R6: the reserved master cannot touch a group owned by anyone else
  a_r6_rsvd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && master == MST_RSVD && owner != MST_RSVD) |-> out_byte == old_byte);
endmodule

// File: rtl/gsf_cmd_src_filter.sv
module gsf_cmd_src_filter
  import gsf_pkg::*;
#(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned DW     = GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               own_wr_lo,
  input  logic               own_wr_hi,
  input  logic [DW-1:0]      own_wdata,
  input  logic [OWNER_W-1:0] wr_master,
  input  logic               wr_protected,
  input  logic [DW-1:0]      old_word,
  input  logic [DW-1:0]      new_word,
  output logic [DW-1:0]      merged_word,
  output logic [DW-1:0]      own_lo_q,
  output logic [DW-1:0]      own_hi_q
);
  logic [GROUPS*OWNER_W-1:0] owners;

  gsf_owner_regs #(
    .GROUPS (GROUPS),
    .GROUP_W(GROUP_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (own_wr_lo),
    .wr_hi (own_wr_hi),
    .wdata (own_wdata),
    .lo_q  (own_lo_q),
    .hi_q  (own_hi_q),
    .owners(owners)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    gsf_group_merge #(
      .GROUP_W(GROUP_W)
    ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .owner   (owners[g*OWNER_W +: OWNER_W]),
      .master  (wr_master),
      .protect (wr_protected),
      .old_byte(old_word[g*GROUP_W +: GROUP_W]),
      .new_byte(new_word[g*GROUP_W +: GROUP_W]),
      .out_byte(merged_word[g*GROUP_W +: GROUP_W])
    );

    // R4: a group not owned by the writer keeps the old byte
    a_r4_foreign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_protected && {own_hi_q[g*GROUP_W], own_lo_q[g*GROUP_W]} != wr_master)
      |-> merged_word[g*GROUP_W +: GROUP_W] == old_word[g*GROUP_W +: GROUP_W]);
    // R4: a group owned by the writer takes the new byte
    a_r4_owned_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_protected && {own_hi_q[g*GROUP_W], own_lo_q[g*GROUP_W]} == wr_master)
      |-> merged_word[g*GROUP_W +: GROUP_W] == new_word[g*GROUP_W +: GROUP_W]);
  end

  // R5: unfiltered registers pass the new value through whole
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_protected |-> merged_word == new_word);
endmodule

// File: tb/gsf_cmd_src_filter_test.sv
module gsf_cmd_src_filter_test;
  localparam int unsigned DW = 32;
  localparam logic [31:0] OLDV = 32'h11223344;
  localparam logic [31:0] NEWV = 32'hCCDDEEFF;
  localparam logic [31:0] MASK = 32'h01010101;
  localparam int unsigned NVEC = 11;

  // {lo write data, hi write data, master, protected, expected merged}
  localparam logic [98:0] VEC [NVEC] = '{
    {32'h00000000, 32'h00000000, 2'd0, 1'b1, 32'hCCDDEEFF}, // R4 main owns all
    {32'h00000000, 32'h00000000, 2'd1, 1'b1, 32'h11223344}, // R4 host owns none
    {32'h00000001, 32'h00000000, 2'd1, 1'b1, 32'h112233FF}, // R3 g0 -> host
    {32'h00000001, 32'h00000000, 2'd0, 1'b1, 32'hCCDDEE44}, // R3 main keeps g1..g3
    {32'h01000100, 32'h01010000, 2'd2, 1'b1, 32'h11DD3344}, // R3 g2 -> coproc
    {32'h01000100, 32'h01010000, 2'd3, 1'b1, 32'hCC223344}, // R6 g3 owner 3
    {32'h01000100, 32'h01010000, 2'd1, 1'b1, 32'h1122EE44}, // R3 g1 -> host
    {32'h01000100, 32'h01010000, 2'd0, 1'b1, 32'h112233FF}, // R3 g0 -> main
    {32'hFFFFFFFF, 32'h00000000, 2'd1, 1'b1, 32'hCCDDEEFF}, // R2 mask, host owns all
    {32'hFFFFFFFF, 32'h00000000, 2'd3, 1'b1, 32'h11223344}, // R6 reserved blocked
    {32'hFFFFFFFF, 32'h00000000, 2'd3, 1'b0, 32'hCCDDEEFF}  // R5 bypass
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          own_wr_lo = 1'b0;
  logic          own_wr_hi = 1'b0;
  logic [DW-1:0] own_wdata = '0;
  logic [1:0]    wr_master = 2'd0;
  logic          wr_protected = 1'b1;
  logic [DW-1:0] old_word = OLDV;
  logic [DW-1:0] new_word = NEWV;
  logic [DW-1:0] merged_word;
  logic [DW-1:0] own_lo_q;
  logic [DW-1:0] own_hi_q;

  int n_tot = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gsf_cmd_src_filter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .own_wr_lo   (own_wr_lo),
    .own_wr_hi   (own_wr_hi),
    .own_wdata   (own_wdata),
    .wr_master   (wr_master),
    .wr_protected(wr_protected),
    .old_word    (old_word),
    .new_word    (new_word),
    .merged_word (merged_word),
    .own_lo_q    (own_lo_q),
    .own_hi_q    (own_hi_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 lo in reset", own_lo_q, 32'h0);
    check("R1 hi in reset", own_hi_q, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1 main owns all after reset", merged_word, NEWV);

    // table walk; ownership written under the vector's master (R7)
    for (int i = 0; i < int'(NVEC); i++) begin
      @(negedge clk);
      wr_master = VEC[i][34:33];
      own_wdata = VEC[i][98:67];
      own_wr_lo = 1'b1;
      @(negedge clk);
      own_wdata = VEC[i][66:35];
      own_wr_lo = 1'b0;
      own_wr_hi = 1'b1;
      @(negedge clk);
      own_wr_hi = 1'b0;
      own_wdata = 32'hDEADBEEF;
      wr_protected = VEC[i][32];
      #2;
      check("R2 R7 lo readback", own_lo_q, VEC[i][98:67] & MASK);
      check("R2 R7 hi readback", own_hi_q, VEC[i][66:35] & MASK);
      check($sformatf("R4 vector %0d", i), merged_word, VEC[i][31:0]);
      wr_protected = 1'b1;
    end

    // R2: idle strobes hold the registers despite changing data
    @(negedge clk); #2;
    check("R2 hold lo", own_lo_q, 32'h01010101);

    // R8: new ownership not visible before the storing edge
    @(negedge clk);
    wr_master = 2'd0;
    own_wdata = 32'h0;
    own_wr_lo = 1'b1;
    own_wr_hi = 1'b1;
    #2;
    check("R8 before edge uses old owners", merged_word, OLDV);
    @(negedge clk);
    own_wr_lo = 1'b0;
    own_wr_hi = 1'b0;
    #2;
    check("R8 after edge uses new owners", merged_word, NEWV);

    // R8: combinational follow of data inputs
    old_word = 32'h0F0F0F0F;
    new_word = 32'hA5A5A5A5;
    wr_master = 2'd2;
    #1;
    check("R8 same-cycle follow", merged_word, 32'h0F0F0F0F);
    old_word = OLDV;
    new_word = NEWV;

    // R3 R6: both strobes in one cycle give group 3 owner 3
    @(negedge clk);
    own_wdata = 32'h01000000;
    own_wr_lo = 1'b1;
    own_wr_hi = 1'b1;
    @(negedge clk);
    own_wr_lo = 1'b0;
    own_wr_hi = 1'b0;
    wr_master = 2'd3;
    #2;
    check("R6 reserved writes own group", merged_word, 32'hCC223344);

    // R1: reset in mid-run clears ownership
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 mid-run reset lo", own_lo_q, 32'h0);
    check("R1 mid-run reset hi", own_hi_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_master = 2'd0;
    #2;
    check("R1 main owns all again", merged_word, NEWV);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tot++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule